// File: doc/BRIEF.md
# Windowed Overvoltage Detector with Consecutive-Window Qualification

This block watches a stream of digitized sense-voltage samples and raises a sticky overvoltage flag. Time is cut into fixed windows of `WIN_CYCLES` clock cycles, about 80 µs each. Inside a window, every sample that arrives with its valid strobe is summed and counted. When the window closes, the block compares the mean of those samples with a programmable limit. It does this without a divider: the sum is compared with the limit multiplied by the sample count.

The limit is set by a 5-bit setting. With the 12-bit ADC scaled so that code 4096 equals 1.6 V, the limit is (89 + setting)/128 of full scale, which spans 111.25 % to 150 % of nominal in 1.25 % steps. A 2-bit qualification field sets how many consecutive windows must all exceed the limit before the flag sets: one, two, three or four. The flag stays set until a clear request arrives. A new configuration byte restarts the current window and the qualification count.

Top module: `ovp_window_detect`

## Requirements
- R1: After reset the flag is 0, the configuration is 0x00 (setting 0, one window needed), and a fresh window starts.
- R2: The limit code is (89 + S) × 32, where S is configuration bits [7:3]. That gives 2848 for S=0, 3072 for S=7, 3328 for S=15 and 3840 for S=31.
- R3: A window lasts `WIN_CYCLES` cycles and counts only cycles where `smp_valid` is high. The window is over the limit when its sample sum exceeds the limit times its sample count. A window with no valid sample is never over.
- R4: The comparison is strict: a window whose mean equals the limit exactly is not over.
- R5: Configuration bits [1:0] = Q require Q+1 consecutive over-limit windows to set the flag. After only Q such windows the flag is still 0. The flag rises on the second clock edge after the edge that closes the qualifying window.
- R6: A window that is not over resets the consecutive count, so an interrupted run must start again from zero.
- R7: Once set, the flag stays set through any windows until `ovp_clr` is high. The clear drops the flag at the next edge, zeroes the consecutive count, restarts the window, and wins over a window that closes in the same cycle.
- R8: A configuration write restarts the current window and zeroes the consecutive count. It does not change the flag.
- R9: Configuration bit 2 has no effect on the limit or on the qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | ADC sample strobe |
| smp_data | input | 12 | Unsigned ADC code, 4096 = 1.6 V |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: [7:3] limit setting, [1:0] window count |
| ovp_clr | input | 1 | Flag clear request |
| ovp_flag | output | 1 | Sticky overvoltage flag |

## Verification
Windows of constant level are fed at the limit and one code above it, for settings 0, 7, 15 and 31 under every count encoding. This separates a strict from a non-strict compare, checks the limit arithmetic, and catches early or late qualification. Windows of mixed level and windows with gapped strobes show that the mean is taken over valid samples only. A window with no strobe at all checks the empty-window case. Interrupted runs, a mid-window configuration write and a clear that arrives between two over-limit windows show the restart rules. Seeded random windows close to the limit then mix all these effects.

// File: rtl/ovpq_pkg.sv
package ovpq_pkg;
    localparam int ADC_W      = 12;
    localparam int SET_W      = 5;
    localparam int NEED_W     = 2;
    localparam int CFG_W      = 8;
    localparam int SET_LSB    = 3;
    localparam int NEED_LSB   = 0;
    localparam int SPARE_BIT  = 2;
    localparam int LIM_OFFSET = 89;
    localparam int LIM_SHIFT  = 7;

    typedef struct packed {
        logic [SET_W-1:0]  setting;
        logic [NEED_W-1:0] need;
    } ovp_cfg_t;
endpackage

// File: rtl/ovpq_threshold.sv
module ovpq_threshold #(
    parameter int ADC_W      = ovpq_pkg::ADC_W,
    parameter int SET_W      = ovpq_pkg::SET_W,
    parameter int LIM_OFFSET = ovpq_pkg::LIM_OFFSET,
    parameter int LIM_SHIFT  = ovpq_pkg::LIM_SHIFT
) (
    input  logic [SET_W-1:0] setting,
    output logic [ADC_W-1:0] limit
);
    localparam int BASE_W = SET_W + 8;
    localparam int PROD_W = BASE_W + ADC_W;

    logic [BASE_W-1:0] base;
    logic [PROD_W-1:0] scaled;
    logic [PROD_W-1:0] shifted;

    // fraction of full scale: (offset + setting) / 2^LIM_SHIFT, times 2^ADC_W
    always_comb begin
        base    = BASE_W'(LIM_OFFSET) + BASE_W'(setting);
        scaled  = PROD_W'(base) << ADC_W;
        shifted = scaled >> LIM_SHIFT;
        limit   = ADC_W'(shifted);
    end
endmodule

// File: rtl/ovpq_window.sv
module ovpq_window #(
    parameter int ADC_W      = ovpq_pkg::ADC_W,
    parameter int WIN_CYCLES = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             smp_valid,
    input  logic [ADC_W-1:0] smp_data,
    input  logic [ADC_W-1:0] limit,
    output logic             win_done,
    output logic             win_over
);
    localparam int TMR_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam int SUM_W = ADC_W + CNT_W;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(WIN_CYCLES - 1);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             over;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [SUM_W-1:0] add_v;
    logic [SUM_W-1:0] sum_f;
    logic [CNT_W-1:0] cnt_f;
    logic [SUM_W-1:0] bound;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.over = 1'b0;
        add_v     = smp_valid ? SUM_W'(smp_data) : '0;
        sum_f     = st_q.sum + add_v;
        cnt_f     = st_q.cnt + CNT_W'(smp_valid);
        bound     = SUM_W'(limit) * SUM_W'(cnt_f);
        if (restart) begin
            st_d.tmr = '0;
            st_d.sum = '0;
            st_d.cnt = '0;
        end else if (st_q.tmr == LAST) begin
            st_d.done = 1'b1;
            st_d.over = (cnt_f != '0) && (sum_f > bound);
            st_d.tmr  = '0;
            st_d.sum  = '0;
            st_d.cnt  = '0;
        end else begin
            st_d.tmr = st_q.tmr + 1'b1;
            st_d.sum = sum_f;
            st_d.cnt = cnt_f;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_done = st_q.done;
    assign win_over = st_q.over;
endmodule

// File: rtl/ovpq_qualify.sv
module ovpq_qualify #(
    parameter int NEED_W = ovpq_pkg::NEED_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              restart,
    input  logic              win_done,
    input  logic              win_over,
    input  logic [NEED_W-1:0] need,
    output logic              flag,
    output logic [NEED_W-1:0] run_len
);
    localparam logic [NEED_W:0] RUN_MAX = {1'b0, {NEED_W{1'b1}}};

    typedef struct packed {
        logic [NEED_W-1:0] run;
        logic              flag;
    } q_st_t;

    q_st_t st_d, st_q;
    logic [NEED_W:0] run_nx;
    logic [NEED_W:0] need_n;

    always_comb begin
        st_d   = st_q;
        run_nx = {1'b0, st_q.run} + 1'b1;
        need_n = {1'b0, need} + 1'b1;
        if (clr) begin
            st_d.run  = '0;
            st_d.flag = 1'b0;
        end else if (restart) begin
            st_d.run = '0;
        end else if (win_done) begin
            if (win_over) begin
                st_d.run = (run_nx > RUN_MAX) ? st_q.run : run_nx[NEED_W-1:0];
                if (run_nx >= need_n) st_d.flag = 1'b1;
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag    = st_q.flag;
    assign run_len = st_q.run;
endmodule

// File: rtl/ovp_window_detect.sv
module ovp_window_detect #(
    parameter int WIN_CYCLES = 10000,
    parameter int ADC_W      = ovpq_pkg::ADC_W,
    parameter int CFG_W      = ovpq_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [ADC_W-1:0] smp_data,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             ovp_clr,
    output logic             ovp_flag
);
    import ovpq_pkg::*;

    ovp_cfg_t          cfg_d, cfg_q;
    logic [ADC_W-1:0]  limit;
    logic              win_done;
    logic              win_over;
    logic              win_restart;
    logic [NEED_W-1:0] run_len;
    logic              cfg_spare_unused;

    assign cfg_spare_unused = cfg_wdata[SPARE_BIT];

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.setting = cfg_wdata[SET_LSB +: SET_W];
            cfg_d.need    = cfg_wdata[NEED_LSB +: NEED_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign win_restart = cfg_we | ovp_clr;

    ovpq_threshold #(
        .ADC_W     (ADC_W),
        .SET_W     (SET_W),
        .LIM_OFFSET(LIM_OFFSET),
        .LIM_SHIFT (LIM_SHIFT)
    ) u_thr (
        .setting(cfg_q.setting),
        .limit  (limit)
    );

    ovpq_window #(
        .ADC_W     (ADC_W),
        .WIN_CYCLES(WIN_CYCLES)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (win_restart),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .limit    (limit),
        .win_done (win_done),
        .win_over (win_over)
    );

    ovpq_qualify #(
        .NEED_W(NEED_W)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ovp_clr),
        .restart (cfg_we),
        .win_done(win_done),
        .win_over(win_over),
        .need    (cfg_q.need),
        .flag    (ovp_flag),
        .run_len (run_len)
    );
endmodule

// File: rtl/ovpq_chk.sv
module ovpq_chk #(
    parameter int NEED_W = ovpq_pkg::NEED_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ovp_clr,
    input logic              cfg_we,
    input logic              ovp_flag,
    input logic              win_done,
    input logic              win_over,
    input logic [NEED_W-1:0] run_len
);
    // R7
    clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_clr |=> !ovp_flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_flag && !ovp_clr) |=> ovp_flag);

    // R5
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovp_flag) |-> $past(win_done && win_over));

    // R6
    under_resets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && !win_over) |=> (run_len == '0));

    // R8
    cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!win_done && run_len == '0));

    // R3
    window_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);
endmodule

bind ovp_window_detect ovpq_chk #(.NEED_W(ovpq_pkg::NEED_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovp_clr (ovp_clr),
    .cfg_we  (cfg_we),
    .ovp_flag(ovp_flag),
    .win_done(win_done),
    .win_over(win_over),
    .run_len (run_len)
);

// File: tb/ovp_window_detect_bench.sv
module ovp_window_detect_bench;
    localparam int WIN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       ovp_clr = 1'b0;
    logic       ovp_flag;

    int errors = 0;
    int checks = 0;
    int m_need = 1;
    int m_thr  = 2848;
    int m_run  = 0;
    int m_flag = 0;

    always #4 clk = ~clk;

    ovp_window_detect #(.WIN_CYCLES(WIN)) u_ovp_window_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .ovp_clr  (ovp_clr),
        .ovp_flag (ovp_flag)
    );

    function automatic int thr_of(input int s);
        return ((89 + s) * 4096) / 128;
    endfunction

    function automatic int clip(input int v);
        if (v < 0) return 0;
        if (v > 4095) return 4095;
        return v;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input int d);
        smp_valid = v;
        smp_data  = 12'(d);
        @(negedge clk);
    endtask

    task automatic model_win(input bit over);
        if (over) begin
            m_run++;
            if (m_run >= m_need) m_flag = 1;
        end else begin
            m_run = 0;
        end
    endtask

    task automatic write_cfg(input int b, input bit clr);
        cfg_we    = 1'b1;
        cfg_wdata = 8'(b);
        ovp_clr   = clr;
        step(0, 0);
        cfg_we  = 1'b0;
        ovp_clr = 1'b0;
        m_need  = (b & 3) + 1;
        m_thr   = thr_of((b >> 3) & 31);
        m_run   = 0;
        if (clr) m_flag = 0;
    endtask

    task automatic pulse_clr();
        ovp_clr = 1'b1;
        step(0, 0);
        ovp_clr = 1'b0;
        m_run  = 0;
        m_flag = 0;
    endtask

    // even cycles carry a, odd cycles carry b; with gap, odd cycles are unstrobed
    task automatic win_pat(input int a, input int b, input bit gap);
        int sum = 0;
        int cnt = 0;
        for (int i = 0; i < WIN; i++) begin
            if (i % 2 == 0) begin
                step(1, a); sum += a; cnt++;
            end else if (gap) begin
                step(0, b);
            end else begin
                step(1, b); sum += b; cnt++;
            end
        end
        model_win(cnt > 0 && sum > m_thr * cnt);
    endtask

    task automatic win_const(input int v);
        win_pat(v, v, 1'b0);
    endtask

    task automatic win_rand(input int lvl);
        int sum = 0;
        int cnt = 0;
        for (int i = 0; i < WIN; i++) begin
            int d;
            bit v;
            v = ($urandom % 4) != 0;
            d = clip(lvl + int'($urandom % 17) - 8);
            step(v, d);
            if (v) begin sum += d; cnt++; end
        end
        model_win(cnt > 0 && sum > m_thr * cnt);
    endtask

    task automatic settle_check(input string tag);
        step(0, 0);
        step(0, 0);
        step(0, 0);
        check(int'(ovp_flag), m_flag, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int sets[4];
        int hi;
        void'($urandom(32'd4711));
        sets[0] = 0; sets[1] = 7; sets[2] = 15; sets[3] = 31;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(int'(ovp_flag), 0, "R1 flag after reset");
        // R1: reset config is setting 0 / one window: level 2849 trips
        win_const(2849);
        settle_check("R1 default config one window");
        check(m_flag, 1, "R1 model agrees");

        // R2 R4 R5 across settings and count encodings
        for (int si = 0; si < 4; si++) begin
            for (int q = 0; q < 4; q++) begin
                int b = (sets[si] << 3) | q;
                write_cfg(b, 1'b1);
                for (int w = 0; w <= q; w++) win_const(thr_of(sets[si]));
                settle_check("R4 equal-to-limit windows");
                write_cfg(b, 1'b1);
                for (int w = 0; w < q; w++) win_const(thr_of(sets[si]) + 1);
                settle_check("R5 one window short");
                write_cfg(b, 1'b1);
                for (int w = 0; w <= q; w++) win_const(thr_of(sets[si]) + 1);
                settle_check("R2 R5 limit+1 qualifies");
                check(int'(ovp_flag), 1, "R2 flag expected set");
            end
        end

        // R6: interrupted run
        hi = thr_of(15) + 5;
        write_cfg((15 << 3) | 2, 1'b1);
        win_const(hi); win_const(hi); win_const(hi - 10); win_const(hi); win_const(hi);
        settle_check("R6 interrupted run");
        write_cfg((15 << 3) | 2, 1'b1);
        win_const(hi); win_const(hi); win_const(hi - 10);
        win_const(hi); win_const(hi); win_const(hi);
        settle_check("R6 restarted run completes");

        // R7: sticky through low windows, then clear
        win_const(0); win_const(100);
        write_cfg((15 << 3) | 2, 1'b0);
        win_const(0);
        settle_check("R7 flag sticky");
        pulse_clr();
        check(int'(ovp_flag), 0, "R7 clear drops flag");
        // R7: clear between two over windows resets the count
        write_cfg((7 << 3) | 1, 1'b1);
        win_const(4000);
        pulse_clr();
        win_const(4000);
        settle_check("R7 clear resets run");

        // R8: config write mid-window discards partial window
        write_cfg(0, 1'b1);
        for (int i = 0; i < 10; i++) step(1, 4095);
        write_cfg(0, 1'b0);
        win_const(0);
        settle_check("R8 partial window discarded");
        // R8: config write keeps flag
        win_const(4000);
        write_cfg(31 << 3, 1'b0);
        check(int'(ovp_flag), 1, "R8 flag kept on cfg write");

        // R9: bit 2 ignored
        write_cfg((7 << 3) | 4 | 1, 1'b1);
        win_const(thr_of(7)); win_const(thr_of(7));
        settle_check("R9 spare bit equal limit");
        write_cfg((7 << 3) | 4 | 1, 1'b1);
        win_const(thr_of(7) + 1);
        settle_check("R9 spare bit one of two");
        write_cfg((7 << 3) | 4 | 1, 1'b1);
        win_const(thr_of(7) + 1); win_const(thr_of(7) + 1);
        settle_check("R9 spare bit two windows");

        // R3: averaging and strobe gating
        write_cfg(15 << 3, 1'b1);
        win_pat(thr_of(15) + 10, thr_of(15) - 11, 1'b0);
        settle_check("R3 mean below limit");
        write_cfg(15 << 3, 1'b1);
        win_pat(thr_of(15) + 10, thr_of(15) - 9, 1'b0);
        settle_check("R3 mean above limit");
        write_cfg(15 << 3, 1'b1);
        win_pat(thr_of(15) - 1, 4095, 1'b1);
        settle_check("R3 unstrobed data ignored");
        write_cfg(15 << 3, 1'b1);
        win_pat(thr_of(15) + 1, 0, 1'b1);
        settle_check("R3 gapped strobe mean");
        write_cfg(0, 1'b1);
        for (int i = 0; i < WIN; i++) step(0, 4095);
        model_win(1'b0);
        settle_check("R3 empty window");

        // random mix R2..R7
        for (int n = 0; n < 40; n++) begin
            int b = int'($urandom % 256);
            int nw = 1 + int'($urandom % 6);
            write_cfg(b, ($urandom % 3) == 0);
            for (int w = 0; w < nw; w++)
                win_rand(m_thr + int'($urandom % 41) - 20);
            settle_check("R5 R6 random windows");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule